// File: doc/BRIEF.md
# External Bus Cycle Controller

The controller turns single read or write requests from an internal agent into timed cycles on an external, non-multiplexed memory bus with active-low chip select, output enable, write enable and transfer-acknowledge strobes. Every cycle starts from a four-clock skeleton: address drive, strobe assert, data, strobe negate. Three programmable extensions lengthen it: setup clocks come before the strobe, wait clocks keep the strobe asserted longer, and hold clocks keep the address and chip select after the strobe is released. This lets one controller serve slow and fast devices.

The external data port can be narrower than the 32-bit internal word. An access wider than the port is split into little-endian beats, and the beat address advances by the port width in bytes. With burst mode off, each beat is a complete bus cycle of its own. With burst mode on, the address and setup phase is paid once, each beat costs only its data clocks, and the release and hold phase is paid once at the end. The internal side presents a request while the controller reports itself ready. It receives a one-clock response pulse carrying the read data once the bus activity has ended.

Top module: `ebc_ctrl`

## Requirements
- R1: Out of reset and whenever idle: `req_ready` is 1, `bus_cs_n`, `bus_oe_n`, `bus_we_n` and `bus_ta_n` are 1, and `bus_wdata_oe` and `rsp_valid` are 0.
- R2: With setup, wait and hold all zero, one bus cycle holds `bus_cs_n` low for exactly 4 clocks, in this order: address only, strobe asserted, data (strobe asserted), strobe released. A read uses `bus_oe_n` as its strobe and a write uses `bus_we_n`.
- R3: A setup count S (0..7) inserts S clocks after the address clock and before the strobe. In these clocks chip select is low, the strobes are high and the address does not change.
- R4: A wait count W (0..7) keeps the strobe low for W extra data clocks. `bus_ta_n` is low only on the last data clock of each beat, and only while a strobe is low.
- R5: A hold count H (0..7) adds H clocks after the strobe is released. In these clocks chip select stays low and the address does not change.
- R6: Read data is taken from `bus_rdata` on the clock where `bus_ta_n` is low. Beat k fills `rsp_rdata` bits [k*PORT_W +: PORT_W]. Bits above the access size (size 0 = byte, 1 = halfword, 2 = word) read 0, and a write returns `rsp_rdata` = 0.
- R7: Beat k drives `bus_addr` = request address + k*PORT_W/8 and `bus_wdata` = write data bits [k*PORT_W +: PORT_W]. `bus_wdata_oe` is 1 only during a write while chip select is low. `bus_addr` and `bus_wdata` read 0 while chip select is high.
- R8: With burst off, an access of N beats (N = max(1, access bytes / port bytes)) runs N full cycles back to back, with chip select low for N*(4+S+W+H) clocks.
- R9: With burst on, chip select is low for 3+S+H+N*(1+W) clocks. The address clock and setup come only once, each beat has 1+W data clocks with the strobe held low, and the release and hold come once at the end.
- R10: `rsp_valid` pulses for exactly one clock, on the clock after the last chip-select-low clock, and `req_ready` returns to 1 on the following clock.
- R11: `req_valid` is taken only while `req_ready` is 1. A request presented while busy has no effect on the bus or the response.
- R12: Direction, size, address, write data and the setup, wait, hold and burst settings are captured when the request is taken. Changing them afterwards does not alter the access in progress. A single-beat access in burst mode is identical to a normal cycle.
- R13: `bus_oe_n` and `bus_we_n` are never low together, and neither is low while `bus_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_setup | input | CNT_W | Setup clocks before the strobe |
| cfg_wait | input | CNT_W | Extra strobe clocks per beat |
| cfg_hold | input | CNT_W | Hold clocks after the strobe release |
| cfg_burst | input | 1 | 1 = beats of a wide access share one address phase |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Write data, little-endian |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Assembled read data |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_ta_n | output | 1 | Transfer acknowledge, active low |
| bus_wdata | output | PORT_W | Write data lanes |
| bus_wdata_oe | output | 1 | Data lanes driven by the controller |
| bus_rdata | input | PORT_W | Read data lanes |

## Verification
The bench's memory model drives valid read data only while `bus_ta_n` is low and a marker value at every other time. A controller that samples too early or on the wrong beat therefore returns the marker bytes, and the model also catches beats assembled in the wrong byte order. The bench runs word accesses that start at 0xFE, so the beat address carries into the next byte, and it sweeps setup, wait and hold in isolation and together. The lengths on the 8-bit port include the six-clock two-wait byte read, the seven-clock write with one clock of each extension, and the seven-clock zero-extension word burst. A controller that repeated the address phase per burst beat, or left out the hold before the next beat, fails both the per-clock comparison and the chip-select length count. Requests injected mid-access and configuration changed after acceptance would show up as altered addresses, strobes or lengths if the controller failed to ignore the one or to latch the other.

// File: rtl/ebc_pkg.sv
`timescale 1ns/1ps
// Shared types of the external bus cycle controller.
// Assumes: one access in flight at a time; states are ordered only for readability.
package ebc_pkg;

    // Phase of the external bus cycle; each state lasts one or more clocks.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_SETUP = 3'd2,
        ST_STRB  = 3'd3,
        ST_DATA  = 3'd4,
        ST_END   = 3'd5,
        ST_HOLD  = 3'd6,
        ST_ACK   = 3'd7
    } ebc_state_e;

endpackage

// File: rtl/ebc_phase_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: walks address, setup, strobe, data, release and hold
// phases for every beat of an access, with one shared down-counter for the
// programmable extensions. Assumes the timing settings and the size are
// sampled only on the accepting clock.
module ebc_phase_fsm
    import ebc_pkg::*;
#(
    parameter int CNT_W      = 3,
    parameter int BEAT_W     = 2,
    parameter int PORT_BYTES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_size,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_wait,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              cfg_burst,
    output ebc_state_e        st_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              accept_o,
    output logic              data_done_o
);

    ebc_state_e        st, st_d;
    logic [CNT_W-1:0]  cnt, cnt_d;
    logic [BEAT_W-1:0] beat, beat_d;
    logic [BEAT_W-1:0] last_q, last_d;
    logic [CNT_W-1:0]  setup_q, wait_q, hold_q;
    logic              burst_q;
    logic              at_last;

    assign accept_o    = (st == ST_IDLE) && req_valid;
    assign data_done_o = (st == ST_DATA) && (cnt == '0);
    assign at_last     = (beat == last_q);
    assign st_o        = st;
    assign beat_o      = beat;

    // Index of the final beat for the requested size and port width.
    always_comb begin
        int nbytes;
        int nbeats;
        nbytes = (req_size == 2'd0) ? 1 : ((req_size == 2'd1) ? 2 : 4);
        nbeats = (nbytes > PORT_BYTES) ? (nbytes / PORT_BYTES) : 1;
        last_d = BEAT_W'(nbeats - 1);
    end

    // Next phase, extension counter and beat index.
    always_comb begin
        st_d   = st;
        cnt_d  = cnt;
        beat_d = beat;
        case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d   = ST_ADDR;
                    beat_d = '0;
                end
            end
            ST_ADDR: begin
                if (setup_q != '0) begin
                    st_d  = ST_SETUP;
                    cnt_d = setup_q - CNT_W'(1);
                end else begin
                    st_d = ST_STRB;
                end
            end
            ST_SETUP: begin
                if (cnt == '0) st_d = ST_STRB;
                else           cnt_d = cnt - CNT_W'(1);
            end
            ST_STRB: begin
                st_d  = ST_DATA;
                cnt_d = wait_q;
            end
            ST_DATA: begin
                if (cnt != '0) begin
                    cnt_d = cnt - CNT_W'(1);
                end else if (burst_q && !at_last) begin
                    beat_d = beat + BEAT_W'(1);
                    cnt_d  = wait_q;
                end else begin
                    st_d = ST_END;
                end
            end
            ST_END, ST_HOLD: begin
                if (st == ST_END && hold_q != '0) begin
                    st_d  = ST_HOLD;
                    cnt_d = hold_q - CNT_W'(1);
                end else if (st == ST_HOLD && cnt != '0) begin
                    cnt_d = cnt - CNT_W'(1);
                end else if (at_last) begin
                    st_d = ST_ACK;
                end else begin
                    st_d   = ST_ADDR;
                    beat_d = beat + BEAT_W'(1);
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Phase state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            beat <= '0;
        end else begin
            st   <= st_d;
            cnt  <= cnt_d;
            beat <= beat_d;
        end
    end

    // Capture the timing settings and beat count when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '0;
            wait_q  <= '0;
            hold_q  <= '0;
            burst_q <= 1'b0;
            last_q  <= '0;
        end else if (accept_o) begin
            setup_q <= cfg_setup;
            wait_q  <= cfg_wait;
            hold_q  <= cfg_hold;
            burst_q <= cfg_burst;
            last_q  <= last_d;
        end
    end

endmodule

// File: rtl/ebc_bus_drive.sv
`timescale 1ns/1ps
// Bus datapath: holds the captured request, drives address, strobes and
// write lanes from the current phase and beat, and assembles read beats.
// Assumes the phase and beat come from ebc_phase_fsm and that beat k of
// a wide access occupies word bits [k*PORT_W +: PORT_W].
module ebc_bus_drive
    import ebc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int PORT_W  = 8,
    parameter int BEAT_W  = 2,
    parameter int BYTE_SH = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  ebc_state_e        st,
    input  logic [BEAT_W-1:0] beat,
    input  logic              data_done,
    input  logic [PORT_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    output logic              bus_ta_n,
    output logic [PORT_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, size_mask;
    logic [1:0]        size_q;
    logic              write_q;
    logic              on_bus, strobe;

    assign on_bus = (st != ST_IDLE) && (st != ST_ACK);
    assign strobe = (st == ST_STRB) || (st == ST_DATA);

    // Capture the request and collect read beats on their acknowledge clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            size_q  <= '0;
            write_q <= 1'b0;
            rdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            size_q  <= req_size;
            write_q <= req_write;
            rdata_q <= '0;
        end else if (data_done && !write_q) begin
            rdata_q[beat*PORT_W +: PORT_W] <= bus_rdata;
        end
    end

    // Keep only the bytes that belong to the access size.
    always_comb begin
        case (size_q)
            2'd0:    size_mask = DATA_W'(32'h0000_00FF);
            2'd1:    size_mask = DATA_W'(32'h0000_FFFF);
            default: size_mask = '1;
        endcase
    end

    // External pins as a function of phase, beat and direction.
    always_comb begin
        bus_cs_n     = !on_bus;
        bus_oe_n     = !(strobe && !write_q);
        bus_we_n     = !(strobe && write_q);
        bus_ta_n     = !data_done;
        bus_wdata_oe = on_bus && write_q;
        bus_addr     = on_bus ? (addr_q + (ADDR_W'(beat) << BYTE_SH)) : '0;
        bus_wdata    = (on_bus && write_q) ? wdata_q[beat*PORT_W +: PORT_W] : '0;
        rsp_rdata    = rdata_q & size_mask;
    end

endmodule

// File: rtl/ebc_ctrl.sv
`timescale 1ns/1ps
// External bus cycle controller top: accepts one internal request while
// idle, runs it on the external bus with programmable setup, wait and hold
// extensions and optional burst beats, then pulses a one-clock response.
// Assumes DATA_W is a multiple of PORT_W and PORT_W is 8, 16 or 32.
module ebc_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PORT_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_wait,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              cfg_burst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    output logic              bus_ta_n,
    output logic [PORT_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [PORT_W-1:0] bus_rdata
);

    localparam int PORT_BYTES = PORT_W / 8;
    localparam int MAX_BEATS  = DATA_W / PORT_W;
    localparam int BEAT_W     = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
    localparam int BYTE_SH    = $clog2(PORT_BYTES);

    ebc_state_e        st;
    logic [BEAT_W-1:0] beat;
    logic              accept, data_done;

    assign req_ready = (st == ST_IDLE);
    assign rsp_valid = (st == ST_ACK);

    ebc_phase_fsm #(
        .CNT_W      (CNT_W),
        .BEAT_W     (BEAT_W),
        .PORT_BYTES (PORT_BYTES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_size    (req_size),
        .cfg_setup   (cfg_setup),
        .cfg_wait    (cfg_wait),
        .cfg_hold    (cfg_hold),
        .cfg_burst   (cfg_burst),
        .st_o        (st),
        .beat_o      (beat),
        .accept_o    (accept),
        .data_done_o (data_done)
    );

    ebc_bus_drive #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PORT_W  (PORT_W),
        .BEAT_W  (BEAT_W),
        .BYTE_SH (BYTE_SH)
    ) u_drive (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .req_write    (req_write),
        .req_size     (req_size),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .st           (st),
        .beat         (beat),
        .data_done    (data_done),
        .bus_rdata    (bus_rdata),
        .bus_addr     (bus_addr),
        .bus_cs_n     (bus_cs_n),
        .bus_oe_n     (bus_oe_n),
        .bus_we_n     (bus_we_n),
        .bus_ta_n     (bus_ta_n),
        .bus_wdata    (bus_wdata),
        .bus_wdata_oe (bus_wdata_oe),
        .rsp_rdata    (rsp_rdata)
    );

endmodule

// File: rtl/ebc_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for ebc_ctrl, attached through bind. Observes only the
// top-level ports. Assumes synchronous active-low reset.
module ebc_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_cs_n,
    input logic              bus_oe_n,
    input logic              bus_we_n,
    input logic              bus_ta_n,
    input logic              bus_wdata_oe
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n)); // R13
    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> !bus_cs_n); // R13
    AST_TA_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ta_n |-> (!bus_oe_n || !bus_we_n)); // R4
    AST_SETUP_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $fell(bus_oe_n && bus_we_n)) |-> $stable(bus_addr)); // R3
    AST_HOLD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $rose(bus_oe_n && bus_we_n)) |-> $stable(bus_addr)); // R5
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R10
    AST_ACK_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (bus_cs_n && $past(!bus_cs_n))); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_oe_n && bus_we_n && bus_ta_n && !bus_wdata_oe)); // R1
    AST_BUSY_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !rsp_valid) |=> !req_ready); // R11

endmodule

bind ebc_ctrl ebc_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .bus_addr     (bus_addr),
    .bus_cs_n     (bus_cs_n),
    .bus_oe_n     (bus_oe_n),
    .bus_we_n     (bus_we_n),
    .bus_ta_n     (bus_ta_n),
    .bus_wdata_oe (bus_wdata_oe)
);

// File: tb/ebc_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for ebc_ctrl: a behavioural per-clock expectation queue built from
// the requirements, compared against every output on every falling edge.
module ebc_ctrl_tb;

    localparam int PW = 8;
    localparam int PB = PW / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_setup = '0, cfg_wait = '0, cfg_hold = '0;
    logic        cfg_burst = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata, bus_addr;
    logic        bus_cs_n, bus_oe_n, bus_we_n, bus_ta_n, bus_wdata_oe;
    logic [PW-1:0] bus_wdata, bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int cs_cnt   = 0;
    int cyc      = 0;

    typedef struct packed {
        logic        cs_n, oe_n, we_n, ta_n;
        logic [31:0] addr;
        logic        wdoe;
        logic [7:0]  wdata;
        logic        rdy, rv;
        logic [31:0] rdata;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    ebc_ctrl #(.ADDR_W(32), .DATA_W(32), .PORT_W(PW), .CNT_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup(cfg_setup), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_burst(cfg_burst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_ta_n(bus_ta_n), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata)
    );

    // Device model: valid data only while acknowledge is low, marker otherwise.
    function automatic logic [7:0] dev_val(input logic [31:0] a);
        return (a[7:0] * 8'd7) ^ 8'h3C;
    endfunction
    assign bus_rdata = !bus_ta_n ? dev_val(bus_addr) : 8'hEE;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h at t=%0t", tag, got, exp, $time);
        end
    endtask

    function automatic exp_t idle_e();
        exp_t e;
        e = '0;
        e.cs_n = 1'b1; e.oe_n = 1'b1; e.we_n = 1'b1; e.ta_n = 1'b1; e.rdy = 1'b1;
        return e;
    endfunction

    task automatic push_bus(input logic wr, input logic strb, input logic ta,
                            input logic [31:0] a, input logic [7:0] d);
        exp_t e;
        e = '0;
        e.cs_n = 1'b0;
        e.oe_n = !(strb && !wr);
        e.we_n = !(strb && wr);
        e.ta_n = !ta;
        e.addr = a;
        e.wdoe = wr;
        e.wdata = wr ? d : 8'h00;
        exp_q.push_back(e);
    endtask

    // Build the expected per-clock trace of one access from the requirements.
    task automatic build_exp(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                             input logic [31:0] wd, input int s, input int w, input int h,
                             input logic burst);
        int nbytes, nbeats;
        logic [31:0] rd;
        exp_t e;
        nbytes = (sz == 2'd0) ? 1 : ((sz == 2'd1) ? 2 : 4);
        nbeats = (nbytes > PB) ? nbytes / PB : 1;
        rd = '0;
        exp_q.push_back(idle_e());
        if (burst && nbeats > 1) begin
            push_bus(wr, 1'b0, 1'b0, a, wd[7:0]);
            for (int i = 0; i < s; i++) push_bus(wr, 1'b0, 1'b0, a, wd[7:0]);
            push_bus(wr, 1'b1, 1'b0, a, wd[7:0]);
            for (int k = 0; k < nbeats; k++) begin
                logic [31:0] ak;
                ak = a + k * PB;
                for (int i = 0; i < w; i++) push_bus(wr, 1'b1, 1'b0, ak, wd[k*8 +: 8]);
                push_bus(wr, 1'b1, 1'b1, ak, wd[k*8 +: 8]);
                rd[k*8 +: 8] = dev_val(ak);
            end
            for (int i = 0; i <= h; i++)
                push_bus(wr, 1'b0, 1'b0, a + (nbeats - 1) * PB, wd[(nbeats-1)*8 +: 8]);
        end else begin
            for (int k = 0; k < nbeats; k++) begin
                logic [31:0] ak;
                ak = a + k * PB;
                for (int i = 0; i <= s; i++) push_bus(wr, 1'b0, 1'b0, ak, wd[k*8 +: 8]);
                push_bus(wr, 1'b1, 1'b0, ak, wd[k*8 +: 8]);
                for (int i = 0; i < w; i++) push_bus(wr, 1'b1, 1'b0, ak, wd[k*8 +: 8]);
                push_bus(wr, 1'b1, 1'b1, ak, wd[k*8 +: 8]);
                for (int i = 0; i <= h; i++) push_bus(wr, 1'b0, 1'b0, ak, wd[k*8 +: 8]);
                rd[k*8 +: 8] = dev_val(ak);
            end
        end
        e = idle_e();
        e.rdy = 1'b0;
        e.rv = 1'b1;
        e.rdata = wr ? 32'h0 : (rd & ((nbytes == 4) ? 32'hFFFF_FFFF : ((32'h1 << (nbytes * 8)) - 1)));
        exp_q.push_back(e);
    endtask

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            e = (exp_q.size() != 0) ? exp_q.pop_front() : idle_e();
            if (!bus_cs_n) cs_cnt++;
            chk("R2 cs/oe/we", {29'd0, bus_cs_n, bus_oe_n, bus_we_n}, {29'd0, e.cs_n, e.oe_n, e.we_n});
            chk("R4 ta_n", {31'd0, bus_ta_n}, {31'd0, e.ta_n});
            chk("R7 bus_addr", bus_addr, e.addr);
            chk("R7 wdata_oe/wdata", {23'd0, bus_wdata_oe, bus_wdata}, {23'd0, e.wdoe, e.wdata});
            chk("R11 req_ready", {31'd0, req_ready}, {31'd0, e.rdy});
            chk("R10 rsp_valid", {31'd0, rsp_valid}, {31'd0, e.rv});
            if (e.rv) chk("R6 rsp_rdata", rsp_rdata, e.rdata);
            chk("R13 strobe exclusion", {31'd0, (!bus_oe_n && !bus_we_n) || ((!bus_oe_n || !bus_we_n) && bus_cs_n)}, 32'd0);
        end
    end

    // mode 0: plain; 1: inject a request while busy; 2: change inputs after accept.
    task automatic do_op(input string tag, input logic wr, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] wd,
                         input int s, input int w, input int h, input logic burst, input int mode);
        int nbytes, nbeats, exp_len;
        nbytes = (sz == 2'd0) ? 1 : ((sz == 2'd1) ? 2 : 4);
        nbeats = (nbytes > PB) ? nbytes / PB : 1;
        exp_len = (burst && nbeats > 1) ? (3 + s + h + nbeats * (1 + w)) : (nbeats * (4 + s + w + h));
        @(posedge clk); #2;
        cfg_setup = 3'(s); cfg_wait = 3'(w); cfg_hold = 3'(h); cfg_burst = burst;
        req_write = wr; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        build_exp(wr, sz, a, wd, s, w, h, burst);
        cs_cnt = 0;
        @(posedge clk); #2;
        req_valid = 1'b0;
        if (mode == 2) begin
            cfg_setup = 3'd7; cfg_wait = 3'd7; cfg_hold = 3'd7; cfg_burst = !burst;
            req_addr = 32'h5555_0000; req_wdata = 32'hA5A5_A5A5; req_write = !wr; req_size = 2'd0;
        end
        if (mode == 1) begin
            @(posedge clk); #2;
            req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_write = !wr; req_size = 2'd2;
            @(posedge clk); #2;
            req_valid = 1'b0;
        end
        while (exp_q.size() != 0) @(posedge clk);
        chk({tag, " cs_n low clocks"}, 32'(cs_cnt), 32'(exp_len));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog expired got=%0d exp<=50000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: idle outputs after reset
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1 strobes", {28'd0, bus_cs_n, bus_oe_n, bus_we_n, bus_ta_n}, 32'hF);
        chk("R1 rsp_valid/wdata_oe", {30'd0, rsp_valid, bus_wdata_oe}, 32'd0);

        do_op("R2 read", 1'b0, 2'd0, 32'h0000_0100, 32'h0, 0, 0, 0, 1'b0, 0);
        do_op("R2 write", 1'b1, 2'd0, 32'h0000_0101, 32'h0000_00C3, 0, 0, 0, 1'b0, 0);
        do_op("R3 setup", 1'b0, 2'd0, 32'h0000_0200, 32'h0, 2, 0, 0, 1'b0, 0);
        do_op("R4 wait2", 1'b0, 2'd0, 32'h0000_0210, 32'h0, 0, 2, 0, 1'b0, 0);
        do_op("R5 hold", 1'b1, 2'd0, 32'h0000_0220, 32'h0000_005A, 0, 0, 3, 1'b0, 0);
        do_op("R5 s1w1h1", 1'b1, 2'd0, 32'h0000_0230, 32'h0000_0077, 1, 1, 1, 1'b0, 0);
        do_op("R8 word read", 1'b0, 2'd2, 32'h0000_00FE, 32'h0, 0, 1, 0, 1'b0, 0);
        do_op("R8 half write", 1'b1, 2'd1, 32'h0000_0300, 32'h0000_BEEF, 1, 0, 1, 1'b0, 0);
        do_op("R9 burst read", 1'b0, 2'd2, 32'h0000_0400, 32'h0, 0, 0, 0, 1'b1, 0);
        do_op("R9 burst write", 1'b1, 2'd2, 32'h0000_04FE, 32'h1234_5678, 2, 1, 2, 1'b1, 0);
        do_op("R9 burst half", 1'b0, 2'd1, 32'h0000_0500, 32'h0, 0, 2, 0, 1'b1, 0);
        do_op("R12 burst single", 1'b0, 2'd0, 32'h0000_0510, 32'h0, 1, 0, 1, 1'b1, 0);
        do_op("R11 busy request", 1'b0, 2'd2, 32'h0000_0600, 32'h0, 0, 0, 1, 1'b0, 1);
        do_op("R12 late change", 1'b1, 2'd2, 32'h0000_0700, 32'hCAFE_F00D, 1, 0, 0, 1'b1, 2);
        do_op("R6 byte after word", 1'b0, 2'd0, 32'h0000_0033, 32'h0, 0, 0, 0, 1'b0, 0);

        repeat (4) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule